// File: doc/BRIEF.md
# Dual-Output Interrupt Aggregator

This block gathers up to 32 level-sensitive interrupt sources and drives two request lines toward a processor: a normal interrupt line and a fast interrupt line. Each line has its own enable mask over the same registered source vector. Software changes a mask only through a pair of write-one-to-set and write-one-to-clear locations, so it never needs a read-modify-write. Status can be read raw or after masking.

Source 0 also has a software-controlled latch. The latch is ORed with hardware input 0, so firmware can raise a test or doorbell interrupt without disturbing the wired source. The register bus is simple: a byte address, a write enable, write data, and read data that is combinational from the address. The index of a register is the byte address shifted right by two.

Top module: `irq_dual_aggregator`

## Requirements
- R1: Each source input is captured into a registered level vector on every clock. Index 1 and index 9 both read that vector, with bit 0 also ORed with the software latch.
- R2: Index 0 reads the level vector ANDed with the normal-line enable mask. Index 8 reads the level vector ANDed with the fast-line enable mask.
- R3: Writing index 2 ORs the written data into the normal-line mask. Writing index 3 clears each mask bit written as one. Index 2 reads the mask back.
- R4: Writing index 10 ORs data into the fast-line mask. Writing index 11 clears each bit written as one. Index 10 reads the mask back.
- R5: Any write to index 4 sets the source-0 software latch, and any write to index 5 clears it. The data value is ignored in both cases. Bit 0 of an index 4 read returns the latch.
- R6: `irqOut` is high exactly when level AND normal mask is nonzero, and `fiqOut` likewise with the fast mask. Both follow a source-input change one clock edge later.
- R7: Writes to indices 0, 1, 8 and 9, writes to undefined indices, and cycles with `wrEn` low change no state.
- R8: Reads of indices 3, 5 and 11 and of undefined indices return zero.
- R9: Reset clears both masks, the software latch and the level vector, so both outputs are low.
- R10: A software clear does not remove a high hardware input 0. A software set keeps bit 0 high while hardware input 0 is low.
- R11: Address bits 1:0 are ignored, and the register index is `addr >> 2`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W (8) | Byte address of the register access |
| wrEn | input | 1 | Write strobe for the current cycle |
| wrData | input | DATA_W (32) | Write data |
| rdData | output | DATA_W (32) | Read data for `addr`, combinational |
| srcIn | input | NUM_SRC (32) | Level-sensitive interrupt sources |
| irqOut | output | 1 | Normal interrupt request |
| fiqOut | output | 1 | Fast interrupt request |

## Verification
On every cycle, the assertions check four things:
- Each mask moves only by the OR or AND-NOT of the written data, and holds when no strobe targets it.
- The level vector follows the inputs one edge late.
- The software latch obeys its set and clear strobes.
- The decoder never raises two strobes at once, and never raises any strobe for a status index.

Only the bench scenarios can show the rest:
- the read-back values and the zero returned for clear-only and undefined indices;
- the OR of the latch with input 0 in both directions;
- the one-edge output latency;
- that the low address bits do not matter;
- the reset state after a reset in the middle of a run.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;

  // Register indices (byte address >> 2); software depends on these values.
  localparam int IdxIrqStat  = 0;
  localparam int IdxRawA     = 1;
  localparam int IdxIrqSet   = 2;
  localparam int IdxIrqClr   = 3;
  localparam int IdxSwSet    = 4;
  localparam int IdxSwClr    = 5;
  localparam int IdxFiqStat  = 8;
  localparam int IdxRawB     = 9;
  localparam int IdxFiqSet   = 10;
  localparam int IdxFiqClr   = 11;

  // Write strobes from decode to datapath.
  typedef struct packed {
    logic irqSet;
    logic irqClr;
    logic fiqSet;
    logic fiqClr;
    logic swSet;
    logic swClr;
  } agg_strobe_t;

  // Read source selection.
  typedef enum logic [2:0] {
    SelNone    = 3'd0,
    SelIrqStat = 3'd1,
    SelRaw     = 3'd2,
    SelIrqEn   = 3'd3,
    SelSw      = 3'd4,
    SelFiqStat = 3'd5,
    SelFiqEn   = 3'd6
  } read_sel_e;

endpackage

// File: rtl/irq_agg_ctrl.sv
module irq_agg_ctrl
  import irq_agg_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  output agg_strobe_t       strb,
  output read_sel_e         rdSel
);

  localparam int IDX_W = ADDR_W - 2;

  localparam logic [IDX_W-1:0] I_IRQ_STAT = IDX_W'(IdxIrqStat);
  localparam logic [IDX_W-1:0] I_RAW_A    = IDX_W'(IdxRawA);
  localparam logic [IDX_W-1:0] I_IRQ_SET  = IDX_W'(IdxIrqSet);
  localparam logic [IDX_W-1:0] I_IRQ_CLR  = IDX_W'(IdxIrqClr);
  localparam logic [IDX_W-1:0] I_SW_SET   = IDX_W'(IdxSwSet);
  localparam logic [IDX_W-1:0] I_SW_CLR   = IDX_W'(IdxSwClr);
  localparam logic [IDX_W-1:0] I_FIQ_STAT = IDX_W'(IdxFiqStat);
  localparam logic [IDX_W-1:0] I_RAW_B    = IDX_W'(IdxRawB);
  localparam logic [IDX_W-1:0] I_FIQ_SET  = IDX_W'(IdxFiqSet);
  localparam logic [IDX_W-1:0] I_FIQ_CLR  = IDX_W'(IdxFiqClr);

  // R11: word index; the byte lane bits take no part in decode.
  logic [IDX_W-1:0] regIdx;
  assign regIdx = addr[ADDR_W-1:2];

  // Write decode: only writable indices raise a strobe (R7).
  always_comb begin
    strb = '0;
    if (wrEn) begin
      case (regIdx)
        I_IRQ_SET: strb.irqSet = 1'b1;
        I_IRQ_CLR: strb.irqClr = 1'b1;
        I_FIQ_SET: strb.fiqSet = 1'b1;
        I_FIQ_CLR: strb.fiqClr = 1'b1;
        I_SW_SET:  strb.swSet  = 1'b1;
        I_SW_CLR:  strb.swClr  = 1'b1;
        default:   strb        = '0;
      endcase
    end
  end

  // Read decode: clear-only and unknown indices select nothing (R8).
  always_comb begin
    case (regIdx)
      I_IRQ_STAT: rdSel = SelIrqStat;
      I_RAW_A:    rdSel = SelRaw;
      I_RAW_B:    rdSel = SelRaw;
      I_IRQ_SET:  rdSel = SelIrqEn;
      I_SW_SET:   rdSel = SelSw;
      I_FIQ_STAT: rdSel = SelFiqStat;
      I_FIQ_SET:  rdSel = SelFiqEn;
      default:    rdSel = SelNone;
    endcase
  end

  // R7: at most one write strobe per cycle.
  a_r7_one_strobe: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strb));

  // R7: status indices never produce a write strobe.
  a_r7_status_no_write: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && (regIdx == I_IRQ_STAT || regIdx == I_RAW_A ||
              regIdx == I_FIQ_STAT || regIdx == I_RAW_B)) |-> (strb == '0));

endmodule

// File: rtl/irq_agg_datapath.sv
module irq_agg_datapath
  import irq_agg_pkg::*;
#(
  parameter int NUM_SRC = 32,
  parameter int DATA_W  = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  agg_strobe_t        strb,
  input  read_sel_e          rdSel,
  input  logic [DATA_W-1:0]  wrData,
  input  logic [NUM_SRC-1:0] srcIn,
  output logic [DATA_W-1:0]  rdData,
  output logic               irqOut,
  output logic               fiqOut
);

  localparam int PAD_W = DATA_W - NUM_SRC;

  logic [NUM_SRC-1:0] levelQ;
  logic [NUM_SRC-1:0] irqEnQ;
  logic [NUM_SRC-1:0] fiqEnQ;
  logic               swQ;
  logic               armedQ;
  logic [NUM_SRC-1:0] wrBits;
  logic [NUM_SRC-1:0] rawEff;
  logic [NUM_SRC-1:0] rdNarrow;

  assign wrBits = wrData[NUM_SRC-1:0];

  // R1: sampled source levels.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) levelQ <= '0;
    else       levelQ <= srcIn;
  end

  // R3 / R4: set and clear enables.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irqEnQ <= '0;
      fiqEnQ <= '0;
    end else begin
      if (strb.irqSet)      irqEnQ <= irqEnQ | wrBits;
      else if (strb.irqClr) irqEnQ <= irqEnQ & ~wrBits;
      if (strb.fiqSet)      fiqEnQ <= fiqEnQ | wrBits;
      else if (strb.fiqClr) fiqEnQ <= fiqEnQ & ~wrBits;
    end
  end

  // R5: software latch for source 0; data value ignored.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           swQ <= 1'b0;
    else if (strb.swSet) swQ <= 1'b1;
    else if (strb.swClr) swQ <= 1'b0;
  end

  // Marks that the previous edge was already out of reset.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) armedQ <= 1'b0;
    else       armedQ <= 1'b1;
  end

  // R10: latch ORed with hardware input 0.
  assign rawEff = levelQ | {{(NUM_SRC-1){1'b0}}, swQ};

  // R6: request lines.
  assign irqOut = |(rawEff & irqEnQ);
  assign fiqOut = |(rawEff & fiqEnQ);

  // R2 / R3 / R4 / R5 / R8: read mux.
  always_comb begin
    case (rdSel)
      SelIrqStat: rdNarrow = rawEff & irqEnQ;
      SelRaw:     rdNarrow = rawEff;
      SelIrqEn:   rdNarrow = irqEnQ;
      SelSw:      rdNarrow = {{(NUM_SRC-1){1'b0}}, swQ};
      SelFiqStat: rdNarrow = rawEff & fiqEnQ;
      SelFiqEn:   rdNarrow = fiqEnQ;
      default:    rdNarrow = '0;
    endcase
  end

  generate
    if (PAD_W > 0) begin : g_pad
      assign rdData = {{PAD_W{1'b0}}, rdNarrow};
    end else begin : g_nopad
      assign rdData = rdNarrow;
    end
  endgenerate

  // R1: level vector follows inputs one edge late.
  a_r1_level_follow: assert property (@(posedge clk) disable iff (!rstN)
    armedQ |-> (levelQ == $past(srcIn)));

  // R3: set ORs in the written bits.
  a_r3_irq_set: assert property (@(posedge clk) disable iff (!rstN)
    (armedQ && $past(strb.irqSet)) |-> (irqEnQ == ($past(irqEnQ) | $past(wrBits))));

  // R3: clear removes the written bits.
  a_r3_irq_clr: assert property (@(posedge clk) disable iff (!rstN)
    (armedQ && $past(strb.irqClr)) |-> (irqEnQ == ($past(irqEnQ) & ~$past(wrBits))));

  // R4: fast-line set and clear.
  a_r4_fiq_set: assert property (@(posedge clk) disable iff (!rstN)
    (armedQ && $past(strb.fiqSet)) |-> (fiqEnQ == ($past(fiqEnQ) | $past(wrBits))));
  a_r4_fiq_clr: assert property (@(posedge clk) disable iff (!rstN)
    (armedQ && $past(strb.fiqClr)) |-> (fiqEnQ == ($past(fiqEnQ) & ~$past(wrBits))));

  // R7: masks hold when not targeted.
  a_r7_irq_hold: assert property (@(posedge clk) disable iff (!rstN)
    (armedQ && !$past(strb.irqSet) && !$past(strb.irqClr)) |-> $stable(irqEnQ));
  a_r7_fiq_hold: assert property (@(posedge clk) disable iff (!rstN)
    (armedQ && !$past(strb.fiqSet) && !$past(strb.fiqClr)) |-> $stable(fiqEnQ));

  // R5: latch obeys its strobes.
  a_r5_sw_set: assert property (@(posedge clk) disable iff (!rstN)
    (armedQ && $past(strb.swSet)) |-> swQ);
  a_r5_sw_clr: assert property (@(posedge clk) disable iff (!rstN)
    (armedQ && $past(strb.swClr)) |-> !swQ);

endmodule

// File: rtl/irq_dual_aggregator.sv
module irq_dual_aggregator
  import irq_agg_pkg::*;
#(
  parameter int NUM_SRC = 32,
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [ADDR_W-1:0]  addr,
  input  logic               wrEn,
  input  logic [DATA_W-1:0]  wrData,
  output logic [DATA_W-1:0]  rdData,
  input  logic [NUM_SRC-1:0] srcIn,
  output logic               irqOut,
  output logic               fiqOut
);

  agg_strobe_t strb;
  read_sel_e   rdSel;

  irq_agg_ctrl #(
    .ADDR_W(ADDR_W)
  ) u_ctrl (
    .clk   (clk),
    .rstN  (rstN),
    .addr  (addr),
    .wrEn  (wrEn),
    .strb  (strb),
    .rdSel (rdSel)
  );

  irq_agg_datapath #(
    .NUM_SRC(NUM_SRC),
    .DATA_W (DATA_W)
  ) u_datapath (
    .clk    (clk),
    .rstN   (rstN),
    .strb   (strb),
    .rdSel  (rdSel),
    .wrData (wrData),
    .srcIn  (srcIn),
    .rdData (rdData),
    .irqOut (irqOut),
    .fiqOut (fiqOut)
  );

endmodule

// File: tb/irq_dual_aggregator_bench.sv
`timescale 1ns/100ps
module irq_dual_aggregator_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  addr = '0;
  logic        wrEn = 1'b0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic [31:0] srcIn = '0;
  logic        irqOut;
  logic        fiqOut;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  irq_dual_aggregator u_irq_dual_aggregator (
    .clk(clk), .rstN(rstN), .addr(addr), .wrEn(wrEn), .wrData(wrData),
    .rdData(rdData), .srcIn(srcIn), .irqOut(irqOut), .fiqOut(fiqOut)
  );

  typedef struct packed {
    logic [7:0]  wAddr;
    logic        wEn;
    logic [31:0] wData;
    logic [31:0] src;
    logic [7:0]  rAddr;
    logic [31:0] expData;
    logic        expIrq;
    logic        expFiq;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VECS [NV] = '{
    '{8'h08, 1'b1, 32'h0000_00F0, 32'h0000_0030, 8'h00, 32'h0000_0030, 1'b1, 1'b0}, // R3 R2 R6
    '{8'h28, 1'b1, 32'h0000_0100, 32'h0000_0100, 8'h20, 32'h0000_0100, 1'b0, 1'b1}, // R4 R2 R6
    '{8'h0C, 1'b1, 32'h0000_0010, 32'h0000_0030, 8'h08, 32'h0000_00E0, 1'b1, 1'b0}, // R3 clear
    '{8'h0C, 1'b1, 32'h0000_0020, 32'h0000_0030, 8'h00, 32'h0000_0000, 1'b0, 1'b0}, // R3 R6 masked off
    '{8'h10, 1'b1, 32'h0000_0000, 32'h0000_0000, 8'h04, 32'h0000_0001, 1'b0, 1'b0}, // R5 R10 sw set, input low
    '{8'h08, 1'b1, 32'h0000_0001, 32'h0000_0000, 8'h00, 32'h0000_0001, 1'b1, 1'b0}, // R5 R6
    '{8'h14, 1'b1, 32'hFFFF_FFFF, 32'h0000_0001, 8'h04, 32'h0000_0001, 1'b1, 1'b0}, // R10 sw clear, hw high
    '{8'h00, 1'b1, 32'hFFFF_FFFF, 32'h0000_0000, 8'h08, 32'h0000_00C1, 1'b0, 1'b0}, // R7 write to status
    '{8'h24, 1'b1, 32'hFFFF_FFFF, 32'h0000_0000, 8'h28, 32'h0000_0100, 1'b0, 1'b0}, // R7 write to raw
    '{8'h2C, 1'b1, 32'h0000_0100, 32'h8000_0000, 8'h28, 32'h0000_0000, 1'b0, 1'b0}, // R4 clear
    '{8'h28, 1'b1, 32'h8000_0000, 32'h8000_0000, 8'h24, 32'h8000_0000, 1'b0, 1'b1}, // R4 R1 top bit
    '{8'hFC, 1'b1, 32'hFFFF_FFFF, 32'h8000_0000, 8'h0C, 32'h0000_0000, 1'b0, 1'b1}, // R7 R8 undefined, clear-only
    '{8'h08, 1'b0, 32'hFFFF_FFFF, 32'h0000_0000, 8'h08, 32'h0000_00C1, 1'b0, 1'b0}, // R7 wrEn low
    '{8'h0B, 1'b1, 32'h0000_0002, 32'h0000_0002, 8'h03, 32'h0000_0002, 1'b1, 1'b0}, // R11 low addr bits
    '{8'h20, 1'b1, 32'hFFFF_FFFF, 32'h0000_0002, 8'h14, 32'h0000_0000, 1'b1, 1'b0}, // R7 R8 idx5 read
    '{8'h10, 1'b1, 32'h1234_0000, 32'h0000_0000, 8'h10, 32'h0000_0001, 1'b1, 1'b0}, // R5 read latch
    '{8'h14, 1'b1, 32'h0000_0000, 32'h0000_0000, 8'h04, 32'h0000_0000, 1'b0, 1'b0}  // R5 clear
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic readAt(input logic [7:0] a, input string req, input logic [31:0] exp);
    addr = a;
    #0.5;
    chk(req, rdData, exp);
  endtask

  initial begin
    // R9: reset state, with all inputs high.
    srcIn = 32'hFFFF_FFFF;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(posedge clk); #0.5;
    chk("R9 irqOut after reset", {31'd0, irqOut}, 32'd0);
    chk("R9 fiqOut after reset", {31'd0, fiqOut}, 32'd0);
    readAt(8'h08, "R9 irq mask", 32'd0);
    readAt(8'h28, "R9 fiq mask", 32'd0);
    readAt(8'h10, "R9 sw latch", 32'd0);
    readAt(8'h04, "R1 raw all high", 32'hFFFF_FFFF);

    // Table walk.
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      addr = VECS[i].wAddr; wrEn = VECS[i].wEn;
      wrData = VECS[i].wData; srcIn = VECS[i].src;
      @(posedge clk); #0.5;
      wrEn = 1'b0; wrData = '0; addr = VECS[i].rAddr;
      #0.5;
      chk($sformatf("vector %0d rdData", i), rdData, VECS[i].expData);
      chk($sformatf("vector %0d irqOut R6", i), {31'd0, irqOut}, {31'd0, VECS[i].expIrq});
      chk($sformatf("vector %0d fiqOut R6", i), {31'd0, fiqOut}, {31'd0, VECS[i].expFiq});
    end

    // R6: one-edge latency (irq mask is now 0xC3).
    @(negedge clk);
    srcIn = 32'h0000_0080;
    #0.5;
    chk("R6 irqOut before edge", {31'd0, irqOut}, 32'd0);
    @(posedge clk); #0.5;
    chk("R6 irqOut after edge", {31'd0, irqOut}, 32'd1);

    // R9: reset in the middle of a run.
    @(negedge clk);
    rstN = 1'b0;
    @(posedge clk); #0.5;
    rstN = 1'b1;
    @(posedge clk); #0.5;
    readAt(8'h08, "R9 irq mask after mid reset", 32'd0);
    readAt(8'h28, "R9 fiq mask after mid reset", 32'd0);
    chk("R9 irqOut after mid reset", {31'd0, irqOut}, 32'd0);
    readAt(8'h04, "R1 raw after mid reset", 32'h0000_0080);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule